// File: doc/BRIEF.md
# Grouped Interrupt Combiner Bank

This block merges a large set of level-sensitive interrupt inputs into a smaller set of lines for a parent interrupt controller. The inputs are split into groups of eight. Each group drives one output line. That line is high while any enabled input in its group is high.

Four groups share one 32-bit register bank, and the banks repeat at a 16-byte address stride. In every bank, software writes one location to set enable bits and a second location to clear them. Writing a zero bit to either location leaves that enable bit as it was. Software can read back the current enables, and it can read a status word that shows which enabled inputs are pending. An interrupt handler reads the status word of the bank that belongs to the asserted line, then services the lowest set bit.

The register port is a single-cycle bus with valid, write, address and data signals. Read data appears registered one cycle after the request.

Top module: `irq_combiner`

## Requirements
- R1: After reset every enable bit is 0, every `irq_o` bit is low even when all inputs are high, and `rdata_o` is 0.
- R2: A write to byte offset 0x0 of a bank sets each enable bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R3: A write to byte offset 0x4 of a bank clears each enable bit whose data bit is 1 and leaves the others unchanged. The change is visible on `irq_o` from the cycle after the write.
- R4: A read of offset 0x0 returns the 32 enable bits of the bank on `rdata_o` in the cycle after the request.
- R5: A read of offset 0xC returns, in the cycle after the request, each input level of the bank ANDed with its enable bit. The input levels are those present at the clock edge of the request.
- R6: `irq_o[n]` is the OR of the gated status of inputs 8n to 8n+7. Those inputs sit in bank n/4, at bits 8*(n%4) to 8*(n%4)+7. The output follows the input levels without a register and stays high while any enabled input of the group is high.
- R7: The bank is selected by address bits [7:4]. A write changes only the enables of the addressed bank.
- R8: Reads of offset 0x4, of offset 0x8, of any offset that is not 0x0, 0x4 or 0xC, and of a bank index at or above the bank count return 0. Writes to any location other than 0x0 and 0x4 of an existing bank change no enable bit.
- R9: In a cycle that follows a cycle with no read request, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_GROUPS*8 (160) | Level-sensitive interrupt inputs |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (8) | Byte address: bits [7:4] select the bank, bits [3:0] the offset |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_GROUPS (20) | One combined line per group |

## Verification
Two events can land in the same cycle. One is an enable write that takes effect at a clock edge. The other is a change of input level in the same cycle. The bench provokes this by driving an enable-set write and raising a single input of that group at the same falling edge. It then checks that the group line stays low before the edge and rises right after it. It clears one enable while a sibling input is still high and expects the line to stay up. It also clears the last contributor and expects the line to drop in the next cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [3:0] OFF_EN_SET = 4'h0;
  localparam logic [3:0] OFF_EN_CLR = 4'h4;
  localparam logic [3:0] OFF_STATUS = 4'hC;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SET,
    SEL_CLR,
    SEL_STAT
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [3:0] off);
    case (off)
      OFF_EN_SET: return SEL_SET;
      OFF_EN_CLR: return SEL_CLR;
      OFF_STATUS: return SEL_STAT;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int GRP_W  = 8,
  parameter int GPB    = 4,
  parameter int N_USED = 4,
  localparam int WORD_W = GRP_W * GPB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] irq_i,
  output logic [WORD_W-1:0] en_o,
  output logic [WORD_W-1:0] status_o
);
  for (genvar g = 0; g < GPB; g++) begin : g_grp
    if (g < N_USED) begin : g_live
      logic [GRP_W-1:0] en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       en_q <= '0;
        else if (set_we_i) en_q <= en_q | wdata_i[g*GRP_W +: GRP_W];
        else if (clr_we_i) en_q <= en_q & ~wdata_i[g*GRP_W +: GRP_W];
      end
      assign en_o[g*GRP_W +: GRP_W] = en_q;
    end else begin : g_absent
      // group lanes past the configured count stay disabled
      assign en_o[g*GRP_W +: GRP_W] = '0;
    end
  end

  assign status_o = irq_i & en_o;
endmodule

// File: rtl/irqc_grp_or.sv
module irqc_grp_or #(
  parameter int NUM_GROUPS = 20,
  parameter int GRP_W      = 8,
  parameter int BUS_W      = 160
) (
  input  logic [BUS_W-1:0]      status_i,
  output logic [NUM_GROUPS-1:0] grp_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_or
    assign grp_o[g] = |status_i[g*GRP_W +: GRP_W];
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 20,
  parameter int GRP_W      = 8,
  parameter int GPB        = 4,
  parameter int ADDR_W     = 8,
  localparam int WORD_W    = GRP_W * GPB,
  localparam int NUM_IN    = NUM_GROUPS * GRP_W,
  localparam int NUM_BANKS = (NUM_GROUPS + GPB - 1) / GPB,
  localparam int PAD_W     = NUM_BANKS * WORD_W,
  localparam int BANK_AW   = ADDR_W - 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_IN-1:0]     irq_i,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [WORD_W-1:0]     req_wdata_i,
  output logic [WORD_W-1:0]     rdata_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [PAD_W-1:0]   irq_pad;
  logic [PAD_W-1:0]   stat_flat;
  logic [WORD_W-1:0]  en_w   [NUM_BANKS];
  logic [WORD_W-1:0]  stat_w [NUM_BANKS];
  logic [BANK_AW-1:0] bank_idx;
  reg_sel_e           sel;
  logic [WORD_W-1:0]  rd_val;
  logic [WORD_W-1:0]  rdata_q;

  assign irq_pad  = PAD_W'(irq_i);
  assign bank_idx = req_addr_i[ADDR_W-1:4];
  assign sel      = decode_off(req_addr_i[3:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int REM    = NUM_GROUPS - b * GPB;
    localparam int N_USED = (REM > GPB) ? GPB : REM;
    logic hit;
    assign hit = req_valid_i && req_write_i && (bank_idx == BANK_AW'(b));

    irqc_bank #(
      .GRP_W (GRP_W),
      .GPB   (GPB),
      .N_USED(N_USED)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_we_i(hit && (sel == SEL_SET)),
      .clr_we_i(hit && (sel == SEL_CLR)),
      .wdata_i (req_wdata_i),
      .irq_i   (irq_pad[b*WORD_W +: WORD_W]),
      .en_o    (en_w[b]),
      .status_o(stat_w[b])
    );
    assign stat_flat[b*WORD_W +: WORD_W] = stat_w[b];
  end

  irqc_grp_or #(
    .NUM_GROUPS(NUM_GROUPS),
    .GRP_W     (GRP_W),
    .BUS_W     (PAD_W)
  ) u_grp_or (
    .status_i(stat_flat),
    .grp_o   (irq_o)
  );

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == BANK_AW'(b)) begin
        case (sel)
          SEL_SET:  rd_val = en_w[b];
          SEL_STAT: rd_val = stat_w[b];
          default:  rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rdata_q <= '0;
    else if (req_valid_i && !req_write_i) rdata_q <= rd_val;
    else                                  rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int NUM_GROUPS = 20,
  parameter int GRP_W      = 8,
  parameter int GPB        = 4,
  parameter int ADDR_W     = 8,
  localparam int WORD_W    = GRP_W * GPB,
  localparam int NUM_IN    = NUM_GROUPS * GRP_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_IN-1:0]     irq_i,
  input logic                  req_valid_i,
  input logic                  req_write_i,
  input logic [ADDR_W-1:0]     req_addr_i,
  input logic [WORD_W-1:0]     req_wdata_i,
  input logic [WORD_W-1:0]     rdata_o,
  input logic [NUM_GROUPS-1:0] irq_o
);
  logic [NUM_GROUPS-1:0] any_in;
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_any
    assign any_in[g] = |irq_i[g*GRP_W +: GRP_W];
  end

  // R9
  rdata_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_valid_i && !req_write_i) |-> rdata_o == '0);

  // R8
  clr_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && !req_write_i && req_addr_i[3:0] == 4'h4) |-> rdata_o == '0);

  // R6
  grp_needs_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~any_in) == '0);

  // R3
  full_clear_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && req_write_i && req_addr_i == ADDR_W'(4) && req_wdata_i == '1)
    |-> irq_o[GPB-1:0] == '0);

  // R5
  status_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && !req_write_i && req_addr_i == ADDR_W'(12))
    |-> (rdata_o & ~$past(irq_i[WORD_W-1:0])) == '0);
endmodule

bind irq_combiner irq_combiner_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .GRP_W     (GRP_W),
  .GPB       (GPB),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o)
);

// File: tb/irq_combiner_bench.sv
`timescale 1ns/1ps
module irq_combiner_bench;
  localparam int NG = 20;
  localparam int NB = 5;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [159:0] irq_v = '0;
  logic         req_valid_i = 1'b0;
  logic         req_write_i = 1'b0;
  logic [7:0]   req_addr_i = '0;
  logic [31:0]  req_wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [19:0]  irq_o;

  logic [31:0]  en_m [NB];
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  irq_combiner u_irq_combiner (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_v),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_irq();
    logic [19:0] r;
    for (int g = 0; g < NG; g++)
      r[g] = |(irq_v[g*8 +: 8] & en_m[g/4][(g%4)*8 +: 8]);
    return r;
  endfunction

  // bus write plus model update per R2, R3, R7, R8
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
    if (a[7:4] < NB) begin
      if (a[3:0] == 4'h0) en_m[a[7:4]] = en_m[a[7:4]] | d;
      else if (a[3:0] == 4'h4) en_m[a[7:4]] = en_m[a[7:4]] & ~d;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 0;
    d = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_o in reset with inputs high", 32'(irq_o), 32'h0);
    chk("R1 rdata in reset", rdata_o, 32'h0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    chk("R1 irq_o after reset", 32'(irq_o), 32'h0);
    for (int b = 0; b < NB; b++) begin
      rd(8'(b*16), d);
      chk("R1 enables zero", d, 32'h0);
    end
    irq_v = '0;
  endtask

  task automatic t_set();
    logic [31:0] d;
    wr(8'h00, 32'h0000_00A5);
    wr(8'h00, 32'h0000_FF00);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, d);
    chk("R2 R4 set accumulates", d, 32'h0000_FFA5);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(8'h04, 32'h0000_0F0F);
    rd(8'h00, d);
    chk("R3 clear selected bits", d, 32'h0000_F0A0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    irq_v[31:0] = 32'h1234_5678;
    rd(8'h0C, d);
    chk("R5 status gated", d, 32'h0000_5020);
    wr(8'h00, 32'hFFFF_0000);
    rd(8'h0C, d);
    chk("R5 status upper groups", d, 32'h1234_5020);
  endtask

  task automatic t_group_or();
    irq_v = '0;
    wr(8'h40, 32'h8000_0001);
    irq_v[128] = 1'b1;
    #1 chk("R6 group 16 bit 0", 32'(irq_o), 32'(exp_irq()));
    irq_v[128] = 1'b0; irq_v[159] = 1'b1;
    #1 chk("R6 group 19 bit 7", 32'(irq_o), 32'(exp_irq()));
    irq_v[158] = 1'b1; irq_v[159] = 1'b0;
    #1 chk("R6 disabled input ignored", 32'(irq_o), 32'(exp_irq()));
    irq_v = {160{1'b1}};
    #1 chk("R6 all inputs high", 32'(irq_o), 32'(exp_irq()));
    irq_v = '0;
  endtask

  task automatic t_bank_iso();
    logic [31:0] d;
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, d);
    chk("R7 bank 3 set", d, 32'hFFFF_FFFF);
    rd(8'h20, d);
    chk("R7 bank 2 untouched", d, en_m[2]);
    rd(8'h40, d);
    chk("R7 bank 4 untouched", d, en_m[4]);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h21, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h20, d);
    chk("R8 writes ignored", d, 32'h0);
    rd(8'h04, d);
    chk("R8 read clear loc", d, 32'h0);
    rd(8'h38, d);
    chk("R8 read 0x8", d, 32'h0);
    rd(8'h32, d);
    chk("R8 read misaligned", d, 32'h0);
    rd(8'h50, d);
    chk("R8 read absent bank", d, 32'h0);
    irq_v = {160{1'b1}};
    #1 chk("R8 outputs unchanged", 32'(irq_o), 32'(exp_irq()));
    irq_v = '0;
  endtask

  task automatic t_idle();
    logic [31:0] d;
    rd(8'h30, d);
    chk("R9 read data present", d, 32'hFFFF_FFFF);
    @(negedge clk_i);
    chk("R9 idle rdata zero", rdata_o, 32'h0);
    wr(8'h30, 32'h0);
    chk("R9 rdata zero after write", rdata_o, 32'h0);
  endtask

  task automatic t_conc();
    // group 5: bank 1, bits 15:8
    irq_v = '0;
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_addr_i = 8'h10; req_wdata_i = 32'h0000_0800;
    irq_v[43] = 1'b1;
    #1 chk("R6 before enable edge", 32'(irq_o[5]), 32'h0);
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
    en_m[1] = en_m[1] | 32'h0000_0800;
    chk("R6 same-cycle enable and input", 32'(irq_o[5]), 32'h1);
    wr(8'h10, 32'h0000_0100);
    irq_v[40] = 1'b1;
    wr(8'h14, 32'h0000_0800);
    chk("R3 R6 sibling holds line", 32'(irq_o[5]), 32'h1);
    wr(8'h14, 32'h0000_0100);
    chk("R3 last contributor cleared", 32'(irq_o[5]), 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    irq_v = {160{1'b1}};
    #1 chk("R3 full clear bank 0", 32'(irq_o[3:0]), 32'h0);
    irq_v = '0;
  endtask

  initial begin
    for (int b = 0; b < NB; b++) en_m[b] = '0;
    irq_v = {160{1'b1}};
    #23;
    t_reset();
    t_set();
    t_clear();
    t_status();
    t_group_or();
    t_bank_iso();
    t_unmapped();
    t_idle();
    t_conc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule